// File: doc/BRIEF.md
# Read-Sequence Command Detector

This block sits beside a memory's access port and watches the stream of completed accesses. Software can ask for a nonvolatile operation without any dedicated pin by issuing six ordinary reads to a fixed, ordered list of addresses. The first five addresses form a shared unlock prefix. The sixth selects one of four commands: copy the working array into nonvolatile cells, copy it back, turn automatic power-down saving off, or turn it back on.

Each completed access arrives as a one-cycle strobe together with its direction and its address. Only a 13-bit window of the address, bits 14 down to 2, is compared. The other bits are free, so the unlock reads can land anywhere that has the right key bits. Any write, or any read that is off the expected path, abandons the attempt. While a command from this block is being carried out downstream, accesses are ignored and the tracker starts again from the beginning.

The outputs are a one-cycle pulse per command, a flag telling the data path to leave the bus floating for the completing read, and a flag showing that a sequence is partly entered.

Top module: `rdseq_cmd_detect`

## Requirements
- R1: After reset, every command pulse, `dq_float` and `seq_active` are low.
- R2: Five reads with key bits equal to those of 0x4E38, 0xB1C7, 0x83E0, 0x7C1F and 0x703F, in that order, followed by a sixth read, issue a command chosen by the sixth address: 0x8FC0 gives store, 0x4C63 gives recall, 0x8B45 gives autosave-off and 0x4B46 gives autosave-on.
- R3: Only address bits 14..2 are compared. Changing bits 18..15 or 1..0 of any of the six reads changes no outcome.
- R4: A write accepted at any step clears the progress and no command comes from that attempt.
- R5: A read that does not match the expected next address clears the progress. If its key equals the key of 0x4E38, it counts as the first step instead.
- R6: Cycles with `acc_valid` low leave the progress unchanged, whatever the address and direction inputs carry. Gaps between the six reads are therefore allowed.
- R7: While `exec_busy` is high, accesses are not tracked and the progress is held at zero.
- R8: A command pulse lasts exactly one cycle and appears in the cycle after the sixth read is accepted. At most one command pulse is high at a time, and `dq_float` is high in exactly the pulse cycle.
- R9: `seq_active` is high exactly when between one and five steps of the sequence have been matched.
- R10: After a complete prefix, a sixth read whose key matches none of the four command addresses issues no command and follows the rule of R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | One-cycle strobe per completed access |
| acc_write | input | 1 | Access direction, 1 = write, 0 = read |
| acc_addr | input | 19 | Address of the access |
| exec_busy | input | 1 | A command is being executed downstream |
| cmd_store | output | 1 | Pulse: save array to nonvolatile cells |
| cmd_recall | output | 1 | Pulse: restore array from nonvolatile cells |
| cmd_as_off | output | 1 | Pulse: disable automatic power-down saving |
| cmd_as_on | output | 1 | Pulse: enable automatic power-down saving |
| seq_active | output | 1 | Part of a sequence has been entered |
| dq_float | output | 1 | Data bus stays high impedance for the completing read |

## Verification
On every cycle, the in-module properties check these behaviours. A write or a busy cycle empties the progress counter. Idle cycles leave it alone. The counter never passes five. Pulses are mutually exclusive, never last two cycles, and only follow a cycle in which the prefix was complete. Only the bench scenarios can show that the address key really selects the right command, that the don't-care bits are ignored, that a stray 0x4E38 restarts as step one, and that an unknown sixth address stays silent. The bench also confirms that each pulse lands exactly one cycle after the sixth read.

// File: rtl/rdseq_pkg.sv
package rdseq_pkg;

    localparam int SEQ_PRE  = 5;
    localparam int SEQ_CMDS = 4;
    localparam int STEP_W   = $clog2(SEQ_PRE + 1);

    typedef enum logic [1:0] {
        CMD_STORE  = 2'd0,
        CMD_RECALL = 2'd1,
        CMD_AS_OFF = 2'd2,
        CMD_AS_ON  = 2'd3
    } cmd_e;

    typedef logic [STEP_W-1:0] step_t;

    typedef struct packed {
        logic hit_next;
        logic hit_first;
        logic hit_cmd;
        cmd_e cmd;
    } match_t;

    typedef struct packed {
        logic fire;
        cmd_e cmd;
    } fire_t;

    function automatic logic [15:0] prefix_addr(input int idx);
        case (idx)
            0:       return 16'h4E38;
            1:       return 16'hB1C7;
            2:       return 16'h83E0;
            3:       return 16'h7C1F;
            4:       return 16'h703F;
            default: return 16'h0000;
        endcase
    endfunction

    function automatic logic [15:0] final_addr(input int idx);
        case (idx)
            0:       return 16'h8FC0;
            1:       return 16'h4C63;
            2:       return 16'h8B45;
            3:       return 16'h4B46;
            default: return 16'h0000;
        endcase
    endfunction

    function automatic cmd_e cmd_of(input int idx);
        case (idx)
            0:       return CMD_STORE;
            1:       return CMD_RECALL;
            2:       return CMD_AS_OFF;
            default: return CMD_AS_ON;
        endcase
    endfunction

endpackage

// File: rtl/rdseq_match.sv
module rdseq_match
    import rdseq_pkg::*;
#(
    parameter int ADDR_W = 19,
    parameter int KEY_HI = 14,
    parameter int KEY_LO = 2
) (
    input  logic [ADDR_W-1:0] addr,
    input  step_t             step,
    output match_t            m
);
    localparam int KEY_W = KEY_HI - KEY_LO + 1;

    logic [KEY_W-1:0]    key;
    logic [SEQ_PRE-1:0]  pre_hit;
    logic [SEQ_CMDS-1:0] fin_hit;
    logic                unused_addr_bits;

    assign key              = addr[KEY_HI:KEY_LO];
    assign unused_addr_bits = ^addr;

    for (genvar g = 0; g < SEQ_PRE; g++) begin : g_pre
        localparam logic [15:0] PA = prefix_addr(g);
        assign pre_hit[g] = (key == PA[KEY_HI:KEY_LO]);
    end

    for (genvar g = 0; g < SEQ_CMDS; g++) begin : g_fin
        localparam logic [15:0] FA = final_addr(g);
        assign fin_hit[g] = (key == FA[KEY_HI:KEY_LO]);
    end

    always_comb begin
        m           = '0;
        m.hit_first = pre_hit[0];
        for (int i = 0; i < SEQ_PRE; i++) begin
            if (step == step_t'(i)) m.hit_next = pre_hit[i];
        end
        if (step == step_t'(SEQ_PRE)) begin
            for (int i = 0; i < SEQ_CMDS; i++) begin
                if (fin_hit[i]) begin
                    m.hit_cmd = 1'b1;
                    m.cmd     = cmd_of(i);
                end
            end
        end
    end

endmodule

// File: rtl/rdseq_step.sv
module rdseq_step
    import rdseq_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   acc_valid,
    input  logic   acc_write,
    input  logic   busy,
    input  match_t m,
    output step_t  step,
    output fire_t  fire
);
    logic take_read;

    assign take_read = acc_valid && !acc_write && !busy;
    assign fire.fire = take_read && m.hit_cmd;
    assign fire.cmd  = m.cmd;

    always_ff @(posedge clk) begin
        if (rst || busy) begin
            step <= '0;
        end else if (acc_valid) begin
            if (acc_write)      step <= '0;
            else if (m.hit_cmd) step <= '0;
            else if (m.hit_next) step <= step + step_t'(1);
            else if (m.hit_first) step <= step_t'(1);
            else                step <= '0;
        end
    end

    // R4: a write empties the progress
    a_r4_write_abort: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && acc_write) |=> (step == '0));

    // R7: busy keeps progress at zero
    a_r7_busy_clear: assert property (@(posedge clk) disable iff (rst)
        busy |=> (step == '0));

    // R6: idle cycles do not move the counter
    a_r6_idle_hold: assert property (@(posedge clk) disable iff (rst)
        (!acc_valid && !busy) |=> $stable(step));

    // R9: counter stays within the prefix length
    a_r9_step_range: assert property (@(posedge clk) disable iff (rst)
        step <= step_t'(SEQ_PRE));

endmodule

// File: rtl/rdseq_pulse.sv
module rdseq_pulse
    import rdseq_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  fire_t               fire,
    output logic [SEQ_CMDS-1:0] pulse,
    output logic                float_o
);
    logic [SEQ_CMDS-1:0] pulse_d;

    for (genvar g = 0; g < SEQ_CMDS; g++) begin : g_dec
        assign pulse_d[g] = fire.fire && (fire.cmd == cmd_of(g));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pulse   <= '0;
            float_o <= 1'b0;
        end else begin
            pulse   <= pulse_d;
            float_o <= fire.fire;
        end
    end

    // R8: never two commands at once
    a_r8_onehot: assert property (@(posedge clk) disable iff (rst)
        $onehot0(pulse));

    // R8: a pulse lasts a single cycle
    a_r8_single_cycle: assert property (@(posedge clk) disable iff (rst)
        (|pulse) |=> !(|pulse));

endmodule

// File: rtl/rdseq_cmd_detect.sv
module rdseq_cmd_detect
    import rdseq_pkg::*;
#(
    parameter int ADDR_W = 19,
    parameter int KEY_HI = 14,
    parameter int KEY_LO = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic              exec_busy,
    output logic              cmd_store,
    output logic              cmd_recall,
    output logic              cmd_as_off,
    output logic              cmd_as_on,
    output logic              seq_active,
    output logic              dq_float
);
    match_t              m;
    step_t               step;
    fire_t               fire;
    logic [SEQ_CMDS-1:0] pulse;

    rdseq_match #(.ADDR_W(ADDR_W), .KEY_HI(KEY_HI), .KEY_LO(KEY_LO)) u_match (
        .addr (acc_addr),
        .step (step),
        .m    (m)
    );

    rdseq_step u_step (
        .clk       (clk),
        .rst       (rst),
        .acc_valid (acc_valid),
        .acc_write (acc_write),
        .busy      (exec_busy),
        .m         (m),
        .step      (step),
        .fire      (fire)
    );

    rdseq_pulse u_pulse (
        .clk     (clk),
        .rst     (rst),
        .fire    (fire),
        .pulse   (pulse),
        .float_o (dq_float)
    );

    assign cmd_store  = pulse[int'(CMD_STORE)];
    assign cmd_recall = pulse[int'(CMD_RECALL)];
    assign cmd_as_off = pulse[int'(CMD_AS_OFF)];
    assign cmd_as_on  = pulse[int'(CMD_AS_ON)];
    assign seq_active = (step != '0);

    // R2: a command only follows a cycle with the full prefix entered
    a_r2_from_full_prefix: assert property (@(posedge clk) disable iff (rst)
        (|pulse) |-> ($past(step) == step_t'(SEQ_PRE)));

endmodule

// File: tb/tb_rdseq_cmd_detect.sv
`timescale 1ns/1ps
module tb_rdseq_cmd_detect;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        acc_valid = 1'b0;
    logic        acc_write = 1'b0;
    logic [18:0] acc_addr = '0;
    logic        exec_busy = 1'b0;
    logic        cmd_store, cmd_recall, cmd_as_off, cmd_as_on, seq_active, dq_float;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 0;

    int exp_code[$];
    int exp_cyc[$];

    logic [18:0] pre [5] = '{19'h04E38, 19'h0B1C7, 19'h083E0, 19'h07C1F, 19'h0703F};
    logic [18:0] fin [4] = '{19'h08FC0, 19'h04C63, 19'h08B45, 19'h04B46};

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    rdseq_cmd_detect dut (
        .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_write(acc_write),
        .acc_addr(acc_addr), .exec_busy(exec_busy), .cmd_store(cmd_store),
        .cmd_recall(cmd_recall), .cmd_as_off(cmd_as_off), .cmd_as_on(cmd_as_on),
        .seq_active(seq_active), .dq_float(dq_float)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // driver: one accepted access; optionally records the expected command
    task automatic access(input bit wr, input logic [18:0] addr, input int expect_code = -1);
        @(negedge clk);
        acc_valid = 1'b1;
        acc_write = wr;
        acc_addr  = addr;
        if (expect_code >= 0) begin
            exp_code.push_back(expect_code);
            exp_cyc.push_back(cyc + 1);
        end
        @(posedge clk);
        #1;
        acc_valid = 1'b0;
        acc_write = 1'b0;
        acc_addr  = 19'h5A5A5;
    endtask

    task automatic prefix(input logic [18:0] mask = '0);
        for (int i = 0; i < 5; i++) access(1'b0, pre[i] ^ mask);
    endtask

    task automatic drain(input string req);
        repeat (3) @(negedge clk);
        chk(exp_code.size() == 0, req, exp_code.size(), 0);
        exp_code.delete();
        exp_cyc.delete();
    endtask

    // monitor: compares produced pulses against the scoreboard queue
    always @(negedge clk) begin
        logic [3:0] p;
        p = {cmd_as_on, cmd_as_off, cmd_recall, cmd_store};
        if (!rst && p != 4'b0) begin
            int code;
            code = (p == 4'b0001) ? 0 : (p == 4'b0010) ? 1 :
                   (p == 4'b0100) ? 2 : (p == 4'b1000) ? 3 : 9;
            chk(dq_float == 1'b1, "R8 float with pulse", dq_float, 1);
            if (exp_code.size() == 0) begin
                chk(1'b0, "R2/R4/R10 unexpected command", code, -1);
            end else begin
                int ec, ecy;
                ec  = exp_code.pop_front();
                ecy = exp_cyc.pop_front();
                chk(code == ec, "R2 command code", code, ec);
                chk(cyc == ecy, "R8 pulse cycle", cyc, ecy);
            end
        end else if (!rst && dq_float) begin
            chk(1'b0, "R8 float without pulse", 1, 0);
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk({cmd_store, cmd_recall, cmd_as_off, cmd_as_on} == 4'b0, "R1 pulses",
            {cmd_store, cmd_recall, cmd_as_off, cmd_as_on}, 0);
        chk(seq_active == 1'b0 && dq_float == 1'b0, "R1 flags", {seq_active, dq_float}, 0);
        @(negedge clk);
        rst = 1'b0;

        // R2 all four commands, R9 activity flag
        for (int c = 0; c < 4; c++) begin
            access(1'b0, pre[0]);
            access(1'b0, pre[1]);
            access(1'b0, pre[2]);
            chk(seq_active == 1'b1, "R9 active mid sequence", seq_active, 1);
            access(1'b0, pre[3]);
            access(1'b0, pre[4]);
            access(1'b0, fin[c], c);
            chk(seq_active == 1'b0, "R9 idle after command", seq_active, 0);
            drain("R2 command issued");
        end

        // R3 don't-care bits 18..15 and 1..0 flipped on every read
        prefix(19'h78003);
        access(1'b0, fin[3] ^ 19'h78003, 3);
        drain("R3 masked bits ignored");
        prefix(19'h48001);
        access(1'b0, fin[1] ^ 19'h30002, 1);
        drain("R3 masked bits ignored recall");

        // R4 a write in the middle aborts
        access(1'b0, pre[0]);
        access(1'b0, pre[1]);
        access(1'b1, pre[2]);
        chk(seq_active == 1'b0, "R4 write clears progress", seq_active, 0);
        access(1'b0, pre[2]);
        access(1'b0, pre[3]);
        access(1'b0, pre[4]);
        access(1'b0, fin[0]);
        drain("R4 no command after write");
        // R4 write as the sixth access
        prefix();
        access(1'b1, fin[0]);
        chk(seq_active == 1'b0, "R4 write at step six", seq_active, 0);
        drain("R4 write at step six no command");

        // R5 mismatch clears, stray first address restarts as step one
        access(1'b0, pre[0]);
        access(1'b0, 19'h01234);
        chk(seq_active == 1'b0, "R5 mismatch clears", seq_active, 0);
        access(1'b0, pre[0]);
        access(1'b0, pre[1]);
        access(1'b0, pre[0]);
        chk(seq_active == 1'b1, "R5 restart counts as step one", seq_active, 1);
        access(1'b0, pre[1]);
        access(1'b0, pre[2]);
        access(1'b0, pre[3]);
        access(1'b0, pre[4]);
        access(1'b0, fin[0], 0);
        drain("R5 sequence after restart");

        // R6 gaps with junk on the bus while the strobe is low
        for (int i = 0; i < 5; i++) begin
            access(1'b0, pre[i]);
            @(negedge clk);
            acc_write = 1'b1;
            acc_addr  = 19'h00000;
            @(negedge clk);
            acc_addr  = fin[2];
            @(posedge clk);
            #1;
            acc_write = 1'b0;
        end
        chk(seq_active == 1'b1, "R6 progress kept across gaps", seq_active, 1);
        access(1'b0, fin[2], 2);
        drain("R6 command after gaps");

        // R7 busy discards progress and ignores accesses
        prefix();
        @(negedge clk);
        exec_busy = 1'b1;
        repeat (2) @(negedge clk);
        chk(seq_active == 1'b0, "R7 busy clears progress", seq_active, 0);
        access(1'b0, fin[0]);
        access(1'b0, pre[0]);
        chk(seq_active == 1'b0, "R7 reads ignored while busy", seq_active, 0);
        @(negedge clk);
        exec_busy = 1'b0;
        access(1'b0, fin[0]);
        chk(seq_active == 1'b0, "R7 restart from zero", seq_active, 0);
        drain("R7 no command around busy");

        // R10 unknown sixth address
        prefix();
        access(1'b0, 19'h01234);
        chk(seq_active == 1'b0, "R10 unknown sixth clears", seq_active, 0);
        drain("R10 no command");
        prefix();
        access(1'b0, pre[0]);
        chk(seq_active == 1'b1, "R10 first address as sixth restarts", seq_active, 1);
        drain("R10 no command on restart");

        // R8 back-to-back sequences each give one pulse
        prefix();
        access(1'b0, fin[1], 1);
        prefix();
        access(1'b0, fin[3], 3);
        drain("R8 consecutive commands");

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule